// File: doc/BRIEF.md
# Word/Long-Word Transfer Width Unit

This block carries out register-to-register load and exchange transfers between two 32-bit register values and decides how many bits each transfer moves. A persistent global width bit selects word (16-bit) or long-word (32-bit) transfers. Separate set and clear commands change that bit. A one-shot width directive overrides the global bit for exactly one following load or exchange and then expires.

The transfer datapath is combinational. The two result values reflect the operation and the width in effect in the same cycle. The global bit and the pending directive are registered, so a command or directive given in cycle t takes effect from cycle t+1. The fixed-width operation class covers arithmetic, shift, logic and I/O. For that class the unit moves no data and does not apply its width to it.

Top module: `xfer_width_unit`

## Requirements
- R1: After reset, `glob_long` and `eff_long` are both 0, meaning word width.
- R2: An exchange (`op`=2'b10) at word width swaps bits [15:0] of the two values. `dst_out[31:16]` equals `dst_in[31:16]` and `src_out[31:16]` equals `src_in[31:16]`.
- R3: An exchange at long-word width gives `dst_out`=`src_in` and `src_out`=`dst_in`.
- R4: A load (`op`=2'b01) at word width gives `dst_out`={`dst_in[31:16]`,`src_in[15:0]`} and `src_out`=`src_in`.
- R5: A load at long-word width gives `dst_out`=`src_in` and `src_out`=`src_in`.
- R6: `set_long` makes `glob_long` 1 from the next cycle on, and `clr_long` makes it 0. The value persists until the next command. When both are asserted together, set wins.
- R7: A directive (`dir_valid`, width `dir_long`: 1 = 32-bit, 0 = 16-bit) sets `eff_long` to `dir_long` from the next cycle on. The next load or exchange consumes it. In the cycle after that transfer, `eff_long` equals `glob_long` again.
- R8: Idle (`op`=2'b00) and fixed-width (`op`=2'b11) cycles give `dst_out`=`dst_in` and `src_out`=`src_in`. These cycles leave a pending directive in place.
- R9: A directive and a global command in the same cycle both take effect. `glob_long` is updated, and the directive still sets the width of the next transfer.
- R10: A directive that arrives in the same cycle as a transfer does not affect that transfer. That transfer consumes any earlier directive, and the new directive governs the following transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 2 | Operation: 00 idle, 01 load, 10 exchange, 11 fixed-width op |
| dst_in | input | 32 | Destination register value |
| src_in | input | 32 | Source register value |
| set_long | input | 1 | Global command: enter long-word width |
| clr_long | input | 1 | Global command: return to word width |
| dir_valid | input | 1 | One-shot width directive present |
| dir_long | input | 1 | Directive width, 1 = 32-bit |
| dst_out | output | 32 | Resulting destination value |
| src_out | output | 32 | Resulting source value |
| glob_long | output | 1 | Persistent global width bit |
| eff_long | output | 1 | Width applied to a transfer in this cycle |

## Verification
The assertions check the following on every cycle:
- the high-half preservation of word-width transfers;
- the full swap at long-word width;
- pass-through for non-transfer operations;
- the one-cycle latency of global commands and directives;
- the return of `eff_long` to the global bit after a consuming transfer.

Only the bench scenarios can show ordering effects that span several operations:
- a directive that survives a run of idle and fixed-width cycles;
- a directive that coincides with a global command;
- a directive that arrives alongside a transfer and so governs only the transfer after it.

// File: rtl/xfer_width_unit.sv
module xfer_width_unit #(
  parameter int REG_W  = 32,
  parameter int HALF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op,
  input  logic [REG_W-1:0] dst_in,
  input  logic [REG_W-1:0] src_in,
  input  logic             set_long,
  input  logic             clr_long,
  input  logic             dir_valid,
  input  logic             dir_long,
  output logic [REG_W-1:0] dst_out,
  output logic [REG_W-1:0] src_out,
  output logic             glob_long,
  output logic             eff_long
);
  localparam int HI_W = REG_W - HALF_W;
  localparam logic [1:0] OP_LOAD = 2'b01;
  localparam logic [1:0] OP_XCHG = 2'b10;

  logic glob_q, pend_q, pend_w_q;
  logic is_load, is_xchg, is_xfer;

  assign is_load  = (op == OP_LOAD);
  assign is_xchg  = (op == OP_XCHG);
  assign is_xfer  = is_load | is_xchg;
  assign glob_long = glob_q;
  assign eff_long  = pend_q ? pend_w_q : glob_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_q   <= 1'b0;
      pend_q   <= 1'b0;
      pend_w_q <= 1'b0;
    end else begin
      if (set_long)      glob_q <= 1'b1;
      else if (clr_long) glob_q <= 1'b0;
      if (dir_valid) begin
        pend_q   <= 1'b1;
        pend_w_q <= dir_long;
      end else if (is_xfer) begin
        pend_q   <= 1'b0;
      end
    end
  end

  logic [REG_W-1:0] src_word, dst_word;
  assign src_word = {dst_in[REG_W-1 -: HI_W], src_in[HALF_W-1:0]};
  assign dst_word = {src_in[REG_W-1 -: HI_W], dst_in[HALF_W-1:0]};

  always_comb begin
    dst_out = dst_in;
    src_out = src_in;
    if (is_xfer) dst_out = eff_long ? src_in : src_word;
    if (is_xchg) src_out = eff_long ? dst_in : dst_word;
  end

  a_r2_word_xchg_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (is_xchg && !eff_long) |-> (dst_out[REG_W-1 -: HI_W] == dst_in[REG_W-1 -: HI_W]
      && src_out[REG_W-1 -: HI_W] == src_in[REG_W-1 -: HI_W]
      && dst_out[HALF_W-1:0] == src_in[HALF_W-1:0]
      && src_out[HALF_W-1:0] == dst_in[HALF_W-1:0]));
  a_r3_long_xchg: assert property (@(posedge clk) disable iff (!rst_n)
    (is_xchg && eff_long) |-> (dst_out == src_in && src_out == dst_in));
  a_r4_word_load: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && !eff_long) |-> (dst_out[REG_W-1 -: HI_W] == dst_in[REG_W-1 -: HI_W]
      && src_out == src_in));
  a_r8_no_xfer_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !is_xfer |-> (dst_out == dst_in && src_out == src_in));
  a_r6_set_next: assert property (@(posedge clk) disable iff (!rst_n)
    set_long |=> glob_long);
  a_r6_clr_next: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_long && !set_long) |=> !glob_long);
  a_r7_dir_next: assert property (@(posedge clk) disable iff (!rst_n)
    dir_valid |=> (eff_long == $past(dir_long)));
  a_r7_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (is_xfer && !dir_valid) |=> (eff_long == glob_long));
endmodule

// File: tb/tb_xfer_width_unit.sv
module tb_xfer_width_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] op = 2'b00;
  logic [31:0] dst_in = '0, src_in = '0;
  logic set_long = 0, clr_long = 0, dir_valid = 0, dir_long = 0;
  logic [31:0] dst_out, src_out;
  logic glob_long, eff_long;

  int checks = 0, errors = 0;
  bit m_glob = 0, m_pend = 0, m_pw = 0;

  xfer_width_unit dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] o, input logic [31:0] d, input logic [31:0] s,
                      input bit st, input bit cl, input bit dv, input bit dl, input string req);
    bit eff;
    logic [31:0] ed, es;
    string dreq;
    @(negedge clk);
    op = o; dst_in = d; src_in = s; set_long = st; clr_long = cl; dir_valid = dv; dir_long = dl;
    #2;
    eff = m_pend ? m_pw : m_glob;
    ed = d; es = s; dreq = "R8";
    if (o == 2'b01) begin
      dreq = eff ? "R5" : "R4";
      ed = eff ? s : {d[31:16], s[15:0]};
    end else if (o == 2'b10) begin
      dreq = eff ? "R3" : "R2";
      ed = eff ? s : {d[31:16], s[15:0]};
      es = eff ? d : {s[31:16], d[15:0]};
    end
    chk({req, " eff_long"}, {31'b0, eff_long}, {31'b0, eff});
    chk({req, " glob_long"}, {31'b0, glob_long}, {31'b0, m_glob});
    chk({dreq, " dst_out"}, dst_out, ed);
    chk({dreq, " src_out"}, src_out, es);
    @(posedge clk);
    if (st) m_glob = 1; else if (cl) m_glob = 0;
    if (dv) begin m_pend = 1; m_pw = dl; end
    else if (o == 2'b01 || o == 2'b10) m_pend = 0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 glob_long", {31'b0, glob_long}, 32'd0);
    chk("R1 eff_long", {31'b0, eff_long}, 32'd0);
    rst_n = 1'b1;
    // R2..R5, R8: sweep of ops x data x global width
    for (int g = 0; g < 2; g++) begin
      if (g == 1) step(2'b00, 0, 0, 1, 0, 0, 0, "R6");
      else step(2'b00, 0, 0, 0, 1, 0, 0, "R6");
      for (int i = 0; i < 24; i++) begin
        for (int o = 0; o < 4; o++) begin
          logic [31:0] a, b;
          a = 32'h9E3779B9 * (i + 1);
          b = ~a ^ (32'(i) << 7) ^ 32'h5A5A0F0F;
          step(o[1:0], a, b, 0, 0, 0, 0, "R6");
        end
      end
    end
    // R6: set and clear together -> set wins; persistence
    step(2'b00, 0, 0, 0, 1, 0, 0, "R6");
    step(2'b00, 0, 0, 1, 1, 0, 0, "R6");
    step(2'b00, 0, 0, 0, 0, 0, 0, "R6");
    step(2'b00, 0, 0, 0, 1, 0, 0, "R6");
    // R7: long directive under word global, consumed, then expiry
    step(2'b00, 0, 0, 0, 0, 1, 1, "R7");
    step(2'b10, 32'h11112222, 32'h33334444, 0, 0, 0, 0, "R7");
    step(2'b10, 32'h11112222, 32'h33334444, 0, 0, 0, 0, "R7");
    // R7: word directive under long global
    step(2'b00, 0, 0, 1, 0, 0, 0, "R7");
    step(2'b00, 0, 0, 0, 0, 1, 0, "R7");
    step(2'b01, 32'hAAAABBBB, 32'hCCCCDDDD, 0, 0, 0, 0, "R7");
    step(2'b01, 32'hAAAABBBB, 32'hCCCCDDDD, 0, 0, 0, 0, "R7");
    // R8: directive survives idle and fixed-width cycles
    step(2'b00, 0, 0, 0, 0, 1, 0, "R8");
    for (int k = 0; k < 6; k++)
      step(k[0] ? 2'b11 : 2'b00, 32'hF0F0F0F0 + k, 32'h0F0F0F0F - k, 0, 0, 0, 0, "R8");
    step(2'b10, 32'h12345678, 32'h9ABCDEF0, 0, 0, 0, 0, "R8");
    step(2'b10, 32'h12345678, 32'h9ABCDEF0, 0, 0, 0, 0, "R8");
    // R9: directive with clear in same cycle
    step(2'b00, 0, 0, 0, 1, 1, 1, "R9");
    step(2'b10, 32'hDEADBEEF, 32'hCAFEF00D, 0, 0, 0, 0, "R9");
    step(2'b10, 32'hDEADBEEF, 32'hCAFEF00D, 0, 0, 0, 0, "R9");
    // R9: directive with set in same cycle
    step(2'b00, 0, 0, 1, 0, 1, 0, "R9");
    step(2'b01, 32'h01234567, 32'h89ABCDEF, 0, 0, 0, 0, "R9");
    step(2'b01, 32'h01234567, 32'h89ABCDEF, 0, 0, 0, 0, "R9");
    // R10: directive arriving with a transfer
    step(2'b00, 0, 0, 0, 1, 1, 1, "R10");
    step(2'b10, 32'h55556666, 32'h77778888, 0, 0, 1, 0, "R10");
    step(2'b10, 32'h55556666, 32'h77778888, 0, 0, 0, 0, "R10");
    step(2'b10, 32'h55556666, 32'h77778888, 0, 0, 0, 0, "R10");
    step(2'b10, 32'h55556666, 32'h77778888, 0, 0, 1, 1, "R10");
    step(2'b10, 32'h55556666, 32'h77778888, 0, 0, 0, 0, "R10");
    // R1: reset returns to word width
    step(2'b00, 0, 0, 1, 0, 1, 1, "R1");
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 glob_long after reset", {31'b0, glob_long}, 32'd0);
    chk("R1 eff_long after reset", {31'b0, eff_long}, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule